// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Network

This block resolves the two register operands of the instruction that sits in the execute stage of a 16-bit, eight-register, five-stage in-order pipeline. Each operand arrives as a source specifier and the value read from the register file one cycle earlier. The three instructions ahead of it may not yet be visible in that value. Those instructions are the ones in the execute/memory latch, the memory/writeback latch and a post-writeback latch. The block compares each source specifier with the target specifiers held in those three latches. When a match is found, it replaces the stale operand with the newest result in flight.

The post-writeback level is needed because the register file has no write-through path. A result written in one cycle can only be read in the next cycle, so the instruction that was decoding during that write holds an old copy. The second operand specifier already names the correct field for every instruction: the data register for stores and branches, and the second source for arithmetic. For that reason the block decodes no opcode. Its second resolved operand serves as the ALU input, the store data and the branch-compare input. A target specifier of zero marks an instruction that writes nothing, and source register 0 is never bypassed. A load's execute/memory value is only an address. A separate load-use interlock keeps that case from ever reaching this block.

For each operand the block reports a 2-bit select and the resolved value. A parameter chooses between two output forms: a clocked output stage with synchronous active-high reset, or a purely combinational output.

Top module: `fwd_bypass_unit`

## Requirements
- R1: A nonzero source specifier equal to the execute/memory target gives select 2'b01, and the value is the execute/memory result.
- R2: A nonzero source specifier that matches the memory/writeback target and not the execute/memory target gives select 2'b10, and the value is the memory/writeback result.
- R3: A nonzero source specifier that matches only the post-writeback target gives select 2'b11, and the value is the post-writeback result.
- R4: When several levels match, the youngest wins. The execute/memory level beats memory/writeback, and memory/writeback beats post-writeback.
- R5: A source specifier of 0 is never bypassed. The select is 2'b00 and the value is the operand read in decode, whatever the targets hold.
- R6: A nonzero source specifier that matches no target (including all-zero targets, which mean "no write") gives select 2'b00 and the decode-stage operand.
- R7: The two operands are resolved independently. Both may bypass from the same level or from different levels in the same cycle.
- R8: With OUT_REG=1, selects and values appear on the outputs one clock after the inputs that produced them. With OUT_REG=0 they follow the inputs in the same cycle.
- R9: With OUT_REG=1, a synchronous active-high reset drives both selects to 2'b00 and both values to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| src1_id | input | 3 | First source specifier of the execute-stage instruction |
| src2_id | input | 3 | Second source specifier (data register for store/branch) |
| opnd1_id | input | 16 | First operand read in decode |
| opnd2_id | input | 16 | Second operand read in decode |
| tgt_exm | input | 3 | Target specifier in the execute/memory latch (0 = none) |
| res_exm | input | 16 | Result held in the execute/memory latch |
| tgt_mwb | input | 3 | Target specifier in the memory/writeback latch |
| res_mwb | input | 16 | Write data held in the memory/writeback latch |
| tgt_wbe | input | 3 | Target specifier in the post-writeback latch |
| res_wbe | input | 16 | Data written last cycle, held in the post-writeback latch |
| sel1 | output | 2 | First operand select: 00 none, 01 exec/mem, 10 mem/wb, 11 post-wb |
| val1 | output | 16 | Resolved first operand |
| sel2 | output | 2 | Second operand select, same encoding |
| val2 | output | 16 | Resolved second operand (ALU input, store data, compare input) |

## Verification
The bench builds two copies of the block side by side on the same stimulus. One uses the default OUT_REG=1 and the other uses OUT_REG=0, both with 16-bit data and eight registers. This checks the clocked and combinational output forms against the same expected selects, including their one-cycle latency difference. The eight-register default leaves enough distinct specifiers to place all three levels on the same register, on different registers, and on register 0. That coverage reaches the priority ordering, the zero-specifier rule and independent per-operand bypass in one table.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Select encoding shared by the bypass network and its checker.
  typedef enum logic [1:0] {
    FWD_NONE = 2'b00,
    FWD_EXM  = 2'b01,
    FWD_MWB  = 2'b10,
    FWD_WBE  = 2'b11
  } fwd_sel_e;

  // Number of bypass levels behind the execute stage.
  localparam int NLVL = 3;
endpackage

// File: rtl/fwd_match.sv
// Compares one source specifier against every in-flight target specifier.
module fwd_match #(
  parameter int AW   = 3,
  parameter int NLVL = 3
) (
  input  logic [AW-1:0]           src,
  input  logic [NLVL-1:0][AW-1:0] tgt,
  output logic [NLVL-1:0]         hit
);
  logic src_live;
  assign src_live = |src;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    assign hit[l] = src_live && (tgt[l] == src);
  end
endmodule

// File: rtl/fwd_prio.sv
// Youngest-first priority: level 0 is the nearest instruction.
module fwd_prio #(
  parameter int NLVL = 3,
  parameter int SW   = 2
) (
  input  logic [NLVL-1:0] hit,
  output logic [SW-1:0]   sel
);
  always_comb begin
    sel = '0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (hit[l]) sel = SW'(l + 1);
    end
  end
endmodule

// File: rtl/fwd_mux.sv
// Picks the decode-stage operand or one of the in-flight results.
module fwd_mux #(
  parameter int XLEN = 16,
  parameter int NLVL = 3,
  parameter int SW   = 2
) (
  input  logic [SW-1:0]             sel,
  input  logic [XLEN-1:0]           base,
  input  logic [NLVL-1:0][XLEN-1:0] res,
  output logic [XLEN-1:0]           val
);
  always_comb begin
    val = base;
    for (int l = 0; l < NLVL; l++) begin
      if (sel == SW'(l + 1)) val = res[l];
    end
  end
endmodule

// File: rtl/fwd_bypass_unit.sv
module fwd_bypass_unit #(
  parameter int XLEN    = 16,
  parameter int NREG    = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] src1_id,
  input  logic [$clog2(NREG)-1:0] src2_id,
  input  logic [XLEN-1:0]         opnd1_id,
  input  logic [XLEN-1:0]         opnd2_id,
  input  logic [$clog2(NREG)-1:0] tgt_exm,
  input  logic [XLEN-1:0]         res_exm,
  input  logic [$clog2(NREG)-1:0] tgt_mwb,
  input  logic [XLEN-1:0]         res_mwb,
  input  logic [$clog2(NREG)-1:0] tgt_wbe,
  input  logic [XLEN-1:0]         res_wbe,
  output logic [1:0]              sel1,
  output logic [XLEN-1:0]         val1,
  output logic [1:0]              sel2,
  output logic [XLEN-1:0]         val2
);
  import fwd_pkg::*;

  localparam int AW   = $clog2(NREG);
  localparam int NOPS = 2;
  localparam int SW   = $clog2(NLVL + 1);

  // Level 0 is youngest (exec/mem), level NLVL-1 oldest (post-wb).
  logic [NLVL-1:0][AW-1:0]   lvl_tgt;
  logic [NLVL-1:0][XLEN-1:0] lvl_res;
  assign lvl_tgt = {tgt_wbe, tgt_mwb, tgt_exm};
  assign lvl_res = {res_wbe, res_mwb, res_exm};

  logic [NOPS-1:0][AW-1:0]   op_src;
  logic [NOPS-1:0][XLEN-1:0] op_base;
  assign op_src  = {src2_id, src1_id};
  assign op_base = {opnd2_id, opnd1_id};

  logic [NOPS-1:0][NLVL-1:0] op_hit;
  logic [NOPS-1:0][SW-1:0]   op_sel;
  logic [NOPS-1:0][XLEN-1:0] op_val;

  for (genvar o = 0; o < NOPS; o++) begin : g_op
    fwd_match #(.AW(AW), .NLVL(NLVL)) u_match (
      .src (op_src[o]),
      .tgt (lvl_tgt),
      .hit (op_hit[o])
    );
    fwd_prio #(.NLVL(NLVL), .SW(SW)) u_prio (
      .hit (op_hit[o]),
      .sel (op_sel[o])
    );
    fwd_mux #(.XLEN(XLEN), .NLVL(NLVL), .SW(SW)) u_mux (
      .sel  (op_sel[o]),
      .base (op_base[o]),
      .res  (lvl_res),
      .val  (op_val[o])
    );
  end

  logic [NOPS-1:0][SW-1:0]   out_sel;
  logic [NOPS-1:0][XLEN-1:0] out_val;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int o = 0; o < NOPS; o++) begin
          out_sel[o] <= SW'(FWD_NONE);
          out_val[o] <= '0;
        end
      end else begin
        out_sel <= op_sel;
        out_val <= op_val;
      end
    end
  end else begin : g_comb
    assign out_sel = op_sel;
    assign out_val = op_val;
  end

  assign sel1 = out_sel[0];
  assign val1 = out_val[0];
  assign sel2 = out_sel[1];
  assign val2 = out_val[1];
endmodule

// File: rtl/fwd_bypass_chk.sv
module fwd_bypass_chk #(
  parameter int XLEN    = 16,
  parameter int NREG    = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [$clog2(NREG)-1:0] src1_id,
  input logic [$clog2(NREG)-1:0] src2_id,
  input logic [XLEN-1:0]         opnd1_id,
  input logic [XLEN-1:0]         opnd2_id,
  input logic [$clog2(NREG)-1:0] tgt_exm,
  input logic [XLEN-1:0]         res_exm,
  input logic [$clog2(NREG)-1:0] tgt_mwb,
  input logic [XLEN-1:0]         res_mwb,
  input logic [$clog2(NREG)-1:0] tgt_wbe,
  input logic [XLEN-1:0]         res_wbe,
  input logic [1:0]              sel1,
  input logic [XLEN-1:0]         val1,
  input logic [1:0]              sel2,
  input logic [XLEN-1:0]         val2
);
  if (OUT_REG) begin : g_reg_chk
    // R1
    exm_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (src1_id != 0 && src1_id == tgt_exm) |=> (sel1 == 2'b01 && val1 == $past(res_exm)));
    // R2
    mwb_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (src2_id != 0 && src2_id != tgt_exm && src2_id == tgt_mwb)
      |=> (sel2 == 2'b10 && val2 == $past(res_mwb)));
    // R3
    wbe_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (src1_id != 0 && src1_id != tgt_exm && src1_id != tgt_mwb && src1_id == tgt_wbe)
      |=> (sel1 == 2'b11 && val1 == $past(res_wbe)));
    // R4
    youngest_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (src2_id != 0 && src2_id == tgt_exm && src2_id == tgt_wbe) |=> (sel2 == 2'b01));
    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (rst)
      (src1_id == 0) |=> (sel1 == 2'b00 && val1 == $past(opnd1_id)));
    // R9
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (sel1 == 2'b00 && sel2 == 2'b00 && val1 == 0 && val2 == 0));
  end else begin : g_comb_chk
    // R1
    exm_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (src1_id != 0 && src1_id == tgt_exm) |-> (sel1 == 2'b01 && val1 == res_exm));
    // R2
    mwb_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (src2_id != 0 && src2_id != tgt_exm && src2_id == tgt_mwb)
      |-> (sel2 == 2'b10 && val2 == res_mwb));
    // R3
    wbe_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (src1_id != 0 && src1_id != tgt_exm && src1_id != tgt_mwb && src1_id == tgt_wbe)
      |-> (sel1 == 2'b11 && val1 == res_wbe));
    // R4
    youngest_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (src2_id != 0 && src2_id == tgt_exm && src2_id == tgt_wbe) |-> (sel2 == 2'b01));
    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (rst)
      (src1_id == 0) |-> (sel1 == 2'b00 && val1 == opnd1_id));
  end
endmodule

bind fwd_bypass_unit fwd_bypass_chk #(
  .XLEN(XLEN), .NREG(NREG), .OUT_REG(OUT_REG)
) u_fwd_chk (
  .clk(clk), .rst(rst),
  .src1_id(src1_id), .src2_id(src2_id),
  .opnd1_id(opnd1_id), .opnd2_id(opnd2_id),
  .tgt_exm(tgt_exm), .res_exm(res_exm),
  .tgt_mwb(tgt_mwb), .res_mwb(res_mwb),
  .tgt_wbe(tgt_wbe), .res_wbe(res_wbe),
  .sel1(sel1), .val1(val1), .sel2(sel2), .val2(val2)
);

// File: tb/test_fwd_bypass_unit.sv
module test_fwd_bypass_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 16;
  localparam int NREG = 8;
  localparam int AW   = $clog2(NREG);
  localparam int NVEC = 9;

  localparam logic [XLEN-1:0] OP1 = 16'h1111;
  localparam logic [XLEN-1:0] OP2 = 16'h2222;
  localparam logic [XLEN-1:0] RXM = 16'hAAAA;
  localparam logic [XLEN-1:0] RMW = 16'hBBBB;
  localparam logic [XLEN-1:0] RWE = 16'hCCCC;

  // {src1, src2, tgt_exm, tgt_mwb, tgt_wbe, exp_sel1, exp_sel2}
  localparam logic [18:0] VEC [NVEC] = '{
    {3'd1, 3'd2, 3'd1, 3'd2, 3'd3, 2'd1, 2'd2},  // R1 R2 R7
    {3'd3, 3'd3, 3'd1, 3'd2, 3'd3, 2'd3, 2'd3},  // R3 R7
    {3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 2'd1, 2'd1},  // R4
    {3'd5, 3'd6, 3'd7, 3'd5, 3'd5, 2'd2, 2'd0},  // R4 R6
    {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0},  // R5
    {3'd2, 3'd7, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0},  // R6
    {3'd6, 3'd6, 3'd0, 3'd6, 3'd6, 2'd2, 2'd2},  // R4
    {3'd7, 3'd1, 3'd3, 3'd7, 3'd1, 2'd2, 2'd3},  // R2 R3 R7
    {3'd0, 3'd3, 3'd3, 3'd0, 3'd3, 2'd0, 2'd1}   // R5 R1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] src1_id = '0, src2_id = '0, tgt_exm = '0, tgt_mwb = '0, tgt_wbe = '0;
  logic [XLEN-1:0] opnd1_id = OP1, opnd2_id = OP2, res_exm = RXM, res_mwb = RMW, res_wbe = RWE;
  logic [1:0] sel1, sel2, c_sel1, c_sel2;
  logic [XLEN-1:0] val1, val2, c_val1, c_val2;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_bypass_unit #(.XLEN(XLEN), .NREG(NREG), .OUT_REG(1'b1)) i_fwd_bypass_unit (
    .clk(clk), .rst(rst),
    .src1_id(src1_id), .src2_id(src2_id), .opnd1_id(opnd1_id), .opnd2_id(opnd2_id),
    .tgt_exm(tgt_exm), .res_exm(res_exm), .tgt_mwb(tgt_mwb), .res_mwb(res_mwb),
    .tgt_wbe(tgt_wbe), .res_wbe(res_wbe),
    .sel1(sel1), .val1(val1), .sel2(sel2), .val2(val2)
  );

  fwd_bypass_unit #(.XLEN(XLEN), .NREG(NREG), .OUT_REG(1'b0)) i_fwd_bypass_unit_comb (
    .clk(clk), .rst(rst),
    .src1_id(src1_id), .src2_id(src2_id), .opnd1_id(opnd1_id), .opnd2_id(opnd2_id),
    .tgt_exm(tgt_exm), .res_exm(res_exm), .tgt_mwb(tgt_mwb), .res_mwb(res_mwb),
    .tgt_wbe(tgt_wbe), .res_wbe(res_wbe),
    .sel1(c_sel1), .val1(c_val1), .sel2(c_sel2), .val2(c_val2)
  );

  function automatic logic [XLEN-1:0] exp_val(input logic [1:0] s, input logic [XLEN-1:0] base);
    case (s)
      2'd1:    return RXM;
      2'd2:    return RMW;
      2'd3:    return RWE;
      default: return base;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [18:0] v);
    {src1_id, src2_id, tgt_exm, tgt_mwb, tgt_wbe} = v[18:4];
  endtask

  initial begin
    // Reset with a forwarding pattern on the inputs (R9)
    @(negedge clk);
    drive({3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 4'd0});
    @(posedge clk); #(CLK_PERIOD/4);
    check("R9 reset sel1", 32'(sel1), 32'd0);
    check("R9 reset val1", 32'(val1), 32'd0);
    check("R9 reset sel2", 32'(sel2), 32'd0);
    check("R9 reset val2", 32'(val2), 32'd0);
    @(negedge clk); rst = 1'b0;

    // Table walk: both output forms checked against one expectation (R1-R7 tagged per row)
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      #1;
      // R8: combinational form follows in the same cycle
      check("R8 comb sel1", 32'(c_sel1), 32'(VEC[i][3:2]));
      check("R8 comb val1", 32'(c_val1), 32'(exp_val(VEC[i][3:2], OP1)));
      check("R8 comb sel2", 32'(c_sel2), 32'(VEC[i][1:0]));
      check("R8 comb val2", 32'(c_val2), 32'(exp_val(VEC[i][1:0], OP2)));
      @(posedge clk); #(CLK_PERIOD/4);
      check("R1/R2/R3/R4 sel1", 32'(sel1), 32'(VEC[i][3:2]));
      check("R5/R6 val1", 32'(val1), 32'(exp_val(VEC[i][3:2], OP1)));
      check("R7 sel2", 32'(sel2), 32'(VEC[i][1:0]));
      check("R7 val2", 32'(val2), 32'(exp_val(VEC[i][1:0], OP2)));
      @(negedge clk);
    end

    // R8: registered form lags by one clock
    drive({3'd2, 3'd0, 3'd2, 3'd0, 3'd0, 4'd0});
    @(posedge clk); #(CLK_PERIOD/4);
    check("R8 reg sel1 after edge", 32'(sel1), 32'd1);
    @(negedge clk);
    drive({3'd2, 3'd0, 3'd0, 3'd0, 3'd0, 4'd0});
    #1;
    check("R8 reg sel1 held before edge", 32'(sel1), 32'd1);
    @(posedge clk); #(CLK_PERIOD/4);
    check("R8 reg sel1 updated", 32'(sel1), 32'd0);
    check("R6 reg val1", 32'(val1), 32'(OP1));

    // R5: zero source with all targets zero and a changed operand
    @(negedge clk);
    opnd1_id = 16'h5A5A;
    drive({3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 4'd0});
    @(posedge clk); #(CLK_PERIOD/4);
    check("R5 zero src val1", 32'(val1), 32'h5A5A);
    check("R5 zero src sel2", 32'(sel2), 32'd0);

    // R9: reset in mid-run clears outputs holding a forward
    @(negedge clk);
    drive({3'd4, 3'd4, 3'd4, 3'd0, 3'd0, 4'd0});
    @(posedge clk); #(CLK_PERIOD/4);
    check("R1 before reset", 32'(sel2), 32'd1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R9 mid reset sel2", 32'(sel2), 32'd0);
    check("R9 mid reset val2", 32'(val2), 32'd0);
    @(negedge clk); rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule